// File: doc/BRIEF.md
# USB Host Frame Timer

This block times full-speed USB frames on the host side. Software loads a 14-bit reload value through two byte-wide registers: a low byte and a 6-bit high field. It then sets an enable bit and writes an arm strobe. From then on a down counter, clocked by the 12 MHz bit clock, steps down once per cycle. Each time the count runs out, the block emits a one-clock start-of-frame tick, reloads the counter and advances an 11-bit frame number. A reload of 12000 gives the usual 1 ms frame.

Reading the high register returns the live count shifted right by six. Software uses this value to judge how many bit times remain in the current frame before it starts a transfer. The write view of the high register also carries two mode bits, host/device select and D+/D- polarity swap, which are driven out as plain signals. Any write to the high register restarts frame numbering at zero and sets a sticky full-features flag. Packet building, CRC and line signalling are done elsewhere.

Top module: `usb_frame_timer`

## Requirements
- R1: Register address 0 holds reload bits 7..0 and reads back what was written. Bits 5..0 of a write to address 1 set reload bits 13..8.
- R2: A write of any value to address 3 (arm) loads the counter with the full reload value in that same edge. A read of address 1 then returns reload[13:6].
- R3: While running (enable set and armed), the counter drops by one per clock. A read of address 1 always returns count[13:6]. For a reload of 12000, it reads BBh after 32 clocks and BAh after 33.
- R4: While running, the tick repeats every N clocks for a reload N > 1, and each tick is high for exactly one clock. The counter reloads in the edge that raises the tick.
- R5: The frame number output advances by one in the same edge that raises the tick, and it wraps from 2047 to 0.
- R6: Any write to address 1 clears the frame number. It also sets the full-features output, which then stays set until reset.
- R7: On a write to address 1, data bit 7 sets the host-mode output (1 = host, 0 = device) and data bit 6 sets the polarity-swap output (1 = swapped / low speed, 0 = not swapped / full speed).
- R8: While enable (address 2, bit 0) is clear, or before the first arm, the counter holds its value and no tick is produced.
- R9: A reload value written while a frame is in progress does not change that frame's length. It takes effect from the next reload.
- R10: After reset the counter, frame number, mode bits, full-features flag, enable and arm state are all zero, every register reads 0, and there is no tick.
- R11: A read of address 2 returns the enable bit in bit 0, and a read of address 3 returns the armed state in bit 0. All other bits of these reads are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 12 MHz bit clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe, one cycle per write |
| addr | input | 2 | Register select: 0 reload low, 1 reload high/mode, 2 control, 3 arm |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Combinational read data for `addr` |
| sofTick | output | 1 | One-clock start-of-frame pulse |
| frameNum | output | 11 | Current frame number |
| hostMode | output | 1 | 1 = host, 0 = device |
| polaritySwap | output | 1 | 1 = D+/D- swapped (low speed) |
| fullFeat | output | 1 | Sticky flag set by any write to address 1 |

## Verification
Two conditions are hard to reach from the ports. The first is the frame-number wrap, which needs 2048 ticks. The bench loads a reload of 3, so the wrap arrives after about six thousand clocks, and checks the values on both sides of it. The second is a mid-frame reload change. Here the bench arms with one reload, rewrites the low byte a few clocks later, and then measures both the length of the frame in progress and the length of the next one. The gauge boundary is found by counting clocks from the arm edge and reading the high register on the exact clock where the count crosses a multiple of 64.

// File: rtl/usb_frame_timer_pkg.sv
package usb_frame_timer_pkg;

  typedef enum logic [1:0] {
    REG_TLO  = 2'd0,
    REG_THI  = 2'd1,
    REG_CTRL = 2'd2,
    REG_ARM  = 2'd3
  } regSel_e;

  // control -> datapath strobes
  typedef struct packed {
    logic armLoad;   // load full reload now
    logic run;       // enable && armed
    logic clrFrame;  // restart frame numbering
  } tmrStrobe_t;

endpackage

// File: rtl/usb_frame_timer_regs.sv
module usb_frame_timer_regs
  import usb_frame_timer_pkg::*;
#(
  parameter int CNT_W  = 14,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [1:0]        addr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [CNT_W-1:0]  count,
  output logic [DATA_W-1:0] rdData,
  output logic [CNT_W-1:0]  reload,
  output tmrStrobe_t        strobe,
  output logic              hostMode,
  output logic              polaritySwap,
  output logic              fullFeat
);
  localparam int HI_W        = CNT_W - DATA_W;
  localparam int GAUGE_SHIFT = CNT_W - DATA_W;

  regSel_e           sel;
  logic [DATA_W-1:0] loReg;
  logic [HI_W-1:0]   hiReg;
  logic              enable;
  logic              armed;

  assign sel = regSel_e'(addr);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      loReg        <= '0;
      hiReg        <= '0;
      enable       <= 1'b0;
      armed        <= 1'b0;
      hostMode     <= 1'b0;
      polaritySwap <= 1'b0;
      fullFeat     <= 1'b0;
    end else if (wrEn) begin
      unique case (sel)
        REG_TLO:  loReg <= wrData;
        REG_THI: begin
          hiReg        <= wrData[HI_W-1:0];
          hostMode     <= wrData[DATA_W-1];
          polaritySwap <= wrData[DATA_W-2];
          fullFeat     <= 1'b1;
        end
        REG_CTRL: enable <= wrData[0];
        REG_ARM:  armed  <= 1'b1;
        default:  ;
      endcase
    end
  end

  assign reload = {hiReg, loReg};

  always_comb begin
    strobe          = '0;
    strobe.armLoad  = wrEn && (sel == REG_ARM);
    strobe.clrFrame = wrEn && (sel == REG_THI);
    strobe.run      = enable && armed;
  end

  always_comb begin
    unique case (sel)
      REG_TLO:  rdData = loReg;
      REG_THI:  rdData = count[CNT_W-1:GAUGE_SHIFT];
      REG_CTRL: rdData = {{(DATA_W-1){1'b0}}, enable};
      REG_ARM:  rdData = {{(DATA_W-1){1'b0}}, armed};
      default:  rdData = '0;
    endcase
  end

endmodule

// File: rtl/usb_frame_timer_dp.sv
module usb_frame_timer_dp
  import usb_frame_timer_pkg::*;
#(
  parameter int CNT_W   = 14,
  parameter int FRAME_W = 11
) (
  input  logic               clk,
  input  logic               rstN,
  input  tmrStrobe_t         strobe,
  input  logic [CNT_W-1:0]   reload,
  output logic [CNT_W-1:0]   count,
  output logic               sofTick,
  output logic [FRAME_W-1:0] frameNum
);
  logic expire;

  // last count of the frame: the next edge would reach zero
  assign expire = strobe.run && (count <= CNT_W'(1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      count    <= '0;
      sofTick  <= 1'b0;
      frameNum <= '0;
    end else begin
      sofTick <= 1'b0;
      if (strobe.armLoad) begin
        count <= reload;
      end else if (expire) begin
        count    <= reload;
        sofTick  <= 1'b1;
        frameNum <= frameNum + FRAME_W'(1);
      end else if (strobe.run) begin
        count <= count - CNT_W'(1);
      end
      if (strobe.clrFrame) frameNum <= '0;
    end
  end

endmodule

// File: rtl/usb_frame_timer.sv
module usb_frame_timer
  import usb_frame_timer_pkg::*;
#(
  parameter int CNT_W   = 14,
  parameter int DATA_W  = 8,
  parameter int FRAME_W = 11
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               wrEn,
  input  logic [1:0]         addr,
  input  logic [DATA_W-1:0]  wrData,
  output logic [DATA_W-1:0]  rdData,
  output logic               sofTick,
  output logic [FRAME_W-1:0] frameNum,
  output logic               hostMode,
  output logic               polaritySwap,
  output logic               fullFeat
);
  tmrStrobe_t       strobe;
  logic [CNT_W-1:0] reload;
  logic [CNT_W-1:0] count;

  usb_frame_timer_regs #(.CNT_W(CNT_W), .DATA_W(DATA_W)) regs_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .count(count), .rdData(rdData), .reload(reload), .strobe(strobe),
    .hostMode(hostMode), .polaritySwap(polaritySwap), .fullFeat(fullFeat)
  );

  usb_frame_timer_dp #(.CNT_W(CNT_W), .FRAME_W(FRAME_W)) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .reload(reload),
    .count(count), .sofTick(sofTick), .frameNum(frameNum)
  );

endmodule

// File: rtl/usb_frame_timer_chk.sv
module usb_frame_timer_chk #(
  parameter int CNT_W   = 14,
  parameter int DATA_W  = 8,
  parameter int FRAME_W = 11
) (
  input logic               clk,
  input logic               rstN,
  input logic               wrEn,
  input logic [1:0]         addr,
  input logic [DATA_W-1:0]  wrData,
  input logic               sofTick,
  input logic [FRAME_W-1:0] frameNum,
  input logic               hostMode,
  input logic               polaritySwap,
  input logic               fullFeat,
  input logic [CNT_W-1:0]   count,
  input logic [CNT_W-1:0]   reload,
  input logic               run
);
  logic hiWr;
  logic armWr;
  assign hiWr  = wrEn && (addr == 2'd1);
  assign armWr = wrEn && (addr == 2'd3);

  // R3: one step down per running clock
  a_r3_count_step: assert property (@(posedge clk) disable iff (!rstN)
    (run && count > CNT_W'(1) && !armWr) |=> count == $past(count) - CNT_W'(1));

  // R4: tick lasts one clock when the frame is longer than one clock
  a_r4_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    (sofTick && reload > CNT_W'(1) && !armWr) |=> !sofTick);

  // R5: frame number advances with each tick
  a_r5_frame_step: assert property (@(posedge clk) disable iff (!rstN)
    (sofTick && !$past(hiWr)) |-> frameNum == $past(frameNum) + FRAME_W'(1));

  // R6: high write clears frame number and sets the flag
  a_r6_clear_frame: assert property (@(posedge clk) disable iff (!rstN)
    hiWr |=> (frameNum == '0) && fullFeat);

  a_r6_flag_sticky: assert property (@(posedge clk) disable iff (!rstN)
    fullFeat |=> fullFeat);

  // R7: mode bits follow the high write
  a_r7_mode_bits: assert property (@(posedge clk) disable iff (!rstN)
    hiWr |=> (hostMode == $past(wrData[DATA_W-1])) &&
             (polaritySwap == $past(wrData[DATA_W-2])));

  // R8: stopped counter holds and stays silent
  a_r8_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!run && !armWr) |=> $stable(count) && !sofTick);

endmodule

bind usb_frame_timer usb_frame_timer_chk #(
  .CNT_W(CNT_W), .DATA_W(DATA_W), .FRAME_W(FRAME_W)
) chk_i (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
  .sofTick(sofTick), .frameNum(frameNum), .hostMode(hostMode),
  .polaritySwap(polaritySwap), .fullFeat(fullFeat),
  .count(count), .reload(reload), .run(strobe.run)
);

// File: tb/usb_frame_timer_tb_top.sv
module usb_frame_timer_tb_top;
  localparam int CLK_PERIOD = 84;
  localparam int WATCHDOG   = 190000;

  typedef struct packed {
    logic [7:0]  lo;
    logic [7:0]  hi;
    logic [7:0]  gauge;
    logic [15:0] period;
  } vec_t;

  localparam vec_t VEC [5] = '{
    '{8'hE0, 8'hAE, 8'hBB, 16'd12000},
    '{8'h64, 8'h40, 8'h01, 16'd100},
    '{8'h40, 8'hC0, 8'h01, 16'd64},
    '{8'h05, 8'h00, 8'h00, 16'd5},
    '{8'hFF, 8'hBF, 8'hFF, 16'd16383}
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic [7:0]  wrData = 8'd0;
  logic [7:0]  rdData;
  logic        sofTick;
  logic [10:0] frameNum;
  logic        hostMode, polaritySwap, fullFeat;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  usb_frame_timer dut_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .rdData(rdData), .sofTick(sofTick), .frameNum(frameNum),
    .hostMode(hostMode), .polaritySwap(polaritySwap), .fullFeat(fullFeat)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wrReg(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  // called at a negedge: combinational read, no clock edge consumed
  task automatic rdReg(input logic [1:0] a, output logic [7:0] d);
    addr = a;
    #1;
    d = rdData;
  endtask

  task automatic waitTick();
    do @(negedge clk); while (!sofTick);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!finished) begin
      bad++;
      total++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    logic [7:0] g0;
    int n;
    bit seen;

    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R10: reset state
    for (int a = 0; a < 4; a++) begin
      rdReg(2'(a), d);
      check(d == 8'd0, "R10 read", d, 0);
    end
    check(!sofTick && frameNum == 0, "R10 tick/frame", frameNum, 0);
    check(!hostMode && !polaritySwap && !fullFeat, "R10 mode", {hostMode, polaritySwap, fullFeat}, 0);

    // R8: enabled but not armed -> no tick, count held
    wrReg(2'd0, 8'h05);
    wrReg(2'd2, 8'h01);
    rdReg(2'd2, d);
    check(d == 8'h01, "R11 enable read", d, 1);
    rdReg(2'd3, d);
    check(d == 8'h00, "R11 armed read before arm", d, 0);
    seen = 1'b0;
    repeat (50) begin @(negedge clk); if (sofTick) seen = 1'b1; end
    check(!seen, "R8 no tick before arm", seen, 0);

    // table walk: R1 R2 R4 R5 R6 R7
    for (int i = 0; i < 5; i++) begin
      wrReg(2'd0, VEC[i].lo);
      wrReg(2'd1, VEC[i].hi);
      rdReg(2'd0, d);
      check(d == VEC[i].lo, "R1 low readback", d, VEC[i].lo);
      check(frameNum == 0 && fullFeat, "R6 high write clears frame", frameNum, 0);
      check(hostMode == VEC[i].hi[7], "R7 hostMode", hostMode, VEC[i].hi[7]);
      check(polaritySwap == VEC[i].hi[6], "R7 polaritySwap", polaritySwap, VEC[i].hi[6]);
      wrReg(2'd3, 8'h00);
      rdReg(2'd1, d);
      check(d == VEC[i].gauge, "R2 gauge after arm", d, VEC[i].gauge);
      rdReg(2'd3, d);
      check(d == 8'h01, "R11 armed read", d, 1);
      waitTick();
      check(frameNum == 11'd1, "R5 first tick frame", frameNum, 1);
      n = 0;
      do begin @(negedge clk); n++; end while (!sofTick && n < 20000);
      check(n == int'(VEC[i].period), "R4 period", n, VEC[i].period);
      check(frameNum == 11'd2, "R5 second tick frame", frameNum, 2);
      @(negedge clk);
      check(!sofTick, "R4 pulse width", sofTick, 0);
    end

    // R3: gauge boundary at 12000 reload
    wrReg(2'd0, 8'hE0);
    wrReg(2'd1, 8'hAE);
    wrReg(2'd3, 8'h00);
    repeat (32) @(negedge clk);
    rdReg(2'd1, d);
    check(d == 8'hBB, "R3 gauge after 32", d, 8'hBB);
    @(negedge clk);
    rdReg(2'd1, d);
    check(d == 8'hBA, "R3 gauge after 33", d, 8'hBA);

    // R8: pause via enable clear
    wrReg(2'd2, 8'h00);
    rdReg(2'd1, g0);
    seen = 1'b0;
    repeat (300) begin @(negedge clk); if (sofTick) seen = 1'b1; end
    rdReg(2'd1, d);
    check(d == g0, "R8 gauge held while disabled", d, g0);
    check(!seen, "R8 no tick while disabled", seen, 0);
    wrReg(2'd2, 8'h01);

    // R9: mid-frame reload change
    wrReg(2'd1, 8'h80);
    wrReg(2'd0, 8'd100);
    wrReg(2'd3, 8'h00);
    n = 0;
    do begin
      @(negedge clk);
      n++;
      if (n == 10) begin wrEn = 1'b1; addr = 2'd0; wrData = 8'd50; end
      if (n == 11) wrEn = 1'b0;
    end while (!sofTick && n < 1000);
    check(n == 100, "R9 frame in progress keeps length", n, 100);
    n = 0;
    do begin @(negedge clk); n++; end while (!sofTick && n < 1000);
    check(n == 50, "R9 new length from next reload", n, 50);

    // R5: wrap at 2047 -> 0
    wrReg(2'd1, 8'h80);
    wrReg(2'd0, 8'd3);
    wrReg(2'd3, 8'h00);
    for (int k = 1; k <= 2048; k++) begin
      waitTick();
      if (k == 2047) check(frameNum == 11'd2047, "R5 frame 2047", frameNum, 2047);
      if (k == 2048) check(frameNum == 11'd0, "R5 wrap to 0", frameNum, 0);
    end

    // R6: clear mid-run, flag stays set
    waitTick();
    check(frameNum == 11'd1, "R5 after wrap", frameNum, 1);
    wrReg(2'd1, 8'h00);
    check(frameNum == 11'd0 && fullFeat, "R6 clear mid-run", frameNum, 0);
    check(!hostMode && !polaritySwap, "R7 mode cleared", {hostMode, polaritySwap}, 0);

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule